// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two byte-wide buses, side A and side B, in each of several independent halves (two halves by default, for 16 bits in all). Each half carries data in both directions. The A-to-B path and the B-to-A path each own a storage stage and three active-low controls: a chip enable, a latch enable and an output enable. While the chip enable and the latch enable of a path are both low, the stage is transparent. It follows its input and loads it on every clock edge, and the output shows the input in the same cycle. When the latch enable goes high, or the chip enable goes high, the stage keeps the value it last loaded.

A path drives its far port only while its chip enable and its output enable are both low. Instead of tri-state pins, each port has a data-out bus and a per-bit drive-enable vector. An undriven data-out reads as zero. A per-half flag rises when both directions of that half drive at the same time.

The block carries no streaming traffic: every pin is plain level-sensitive control or data, with no valid/ready handshake and no back-pressure. The input is sampled on the clock, and the data-out and drive-enable outputs are combinational from the controls and the stored state.

Top module: `bus_xcvr16`

## Requirements
- R1: Each half has its own six controls and its own storage, so activity in one half never changes the outputs or stored values of another half.
- R2: With A-to-B chip enable, latch enable and output enable all low (0), the B data-out of that half equals its A input in the same cycle, and the B drive-enable is all ones. The A input is loaded into the A-to-B stage at each clock edge while chip enable and latch enable are low.
- R3: While A-to-B chip enable is high (1), the B drive-enable is all zeros and the B data-out is zero, whatever the latch and output enables are, and the A-to-B stage keeps its value.
- R4: After latch enable goes from low to high with chip enable low, the stage holds the A value loaded at the last clock edge before the change. With chip enable and output enable low, B then shows that held value, whatever A does.
- R5: With chip enable low and output enable high, B is not driven (drive-enable zeros, data-out zero), but the stage still follows A while latch enable is low. The value captured in that state appears on B once output enable goes low with latch enable high.
- R6: The B-to-A path behaves the same way with its own three enables, taking B as input and driving the A data-out and A drive-enable.
- R7: A synchronous active-high reset clears both stages of every half to zero. Right after reset, with chip enable low, latch enable high and output enable low, each port is driven with 0x00.
- R8: A drive-enable vector is always all ones or all zeros for its byte. With every enable high after reset, all data-out, drive-enable and contention outputs are zero.
- R9: A half's contention flag is 1 exactly when its A-to-B and B-to-A paths both drive in the same cycle. The data outputs still follow R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the storage stages |
| rst | input | 1 | Synchronous active-high reset, clears all stages |
| a_in | input | 16 | Side A input data, byte h belongs to half h |
| b_in | input | 16 | Side B input data, byte h belongs to half h |
| ce_ab_n | input | 2 | A-to-B chip enable per half, active low |
| le_ab_n | input | 2 | A-to-B latch enable per half, active low (low = transparent) |
| oe_ab_n | input | 2 | A-to-B output enable per half, active low |
| ce_ba_n | input | 2 | B-to-A chip enable per half, active low |
| le_ba_n | input | 2 | B-to-A latch enable per half, active low (low = transparent) |
| oe_ba_n | input | 2 | B-to-A output enable per half, active low |
| a_out | output | 16 | Data driven onto side A by the B-to-A path, zero when not driven |
| a_oe | output | 16 | Per-bit drive-enable for side A |
| b_out | output | 16 | Data driven onto side B by the A-to-B path, zero when not driven |
| b_oe | output | 16 | Per-bit drive-enable for side B |
| contention | output | 2 | Per-half flag: both directions driving at once |

## Verification
The bench builds the block with its defaults: two halves of eight bits each. This lets one half be exercised while the other stays idle with every enable high, which shows that the halves are independent. A byte width of eight lets the vectors use distinct bit patterns (0x5A, 0x96, 0xE1), so a value taken from the wrong stage or the wrong cycle is visible. The vector walk goes through transparency, holding, chip-enable gating, output-enable gating, the reverse path and contention. Directed steps then cover reset clearing and the second half.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Active-low control triple for one direction of one half
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;

endpackage

// File: rtl/xcvr_dir_stage.sv
module xcvr_dir_stage
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] drv
);

  logic         transparent;
  logic         drive_on;
  logic [W-1:0] held;
  logic [W-1:0] view;

  assign transparent = !ctl.ce_n && !ctl.le_n;
  assign drive_on    = !ctl.ce_n && !ctl.oe_n;

  // Clock-sampled model of the level latch
  always_ff @(posedge clk) begin
    if (rst)              held <= '0;
    else if (transparent) held <= din;
  end

  // Transparent path shows the input in the same cycle
  always_comb begin
    view = transparent ? din : held;
    dout = drive_on ? view : '0;
    drv  = {W{drive_on}};
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.le_n) |=> (held == $past(din)));

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.le_n && !ctl.oe_n) |-> (dout == din));

  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.ce_n || ctl.le_n) |=> $stable(held));

  p_float_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |-> (drv == '0 && dout == '0));

  p_mute_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && ctl.oe_n) |-> (drv == '0));

  p_clear_r7: assert property (@(posedge clk)
    rst |=> (held == '0));

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ab_ctl,
  input  dir_ctl_t     ba_ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         clash
);

  xcvr_dir_stage #(.W(W)) ab_i (
    .clk(clk), .rst(rst), .ctl(ab_ctl), .din(a_in), .dout(b_out), .drv(b_oe)
  );

  xcvr_dir_stage #(.W(W)) ba_i (
    .clk(clk), .rst(rst), .ctl(ba_ctl), .din(b_in), .dout(a_out), .drv(a_oe)
  );

  assign clash = (|a_oe) && (|b_oe);

  p_flag_r9: assert property (@(posedge clk) disable iff (rst)
    clash == (!ab_ctl.ce_n && !ab_ctl.oe_n && !ba_ctl.ce_n && !ba_ctl.oe_n));

  p_whole_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones(a_oe) == 0 || $countones(a_oe) == W) &&
    ($countones(b_oe) == 0 || $countones(b_oe) == W));

endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16
  import xcvr_pkg::*;
#(
  parameter int NUM_HALVES = 2,
  parameter int HALF_W     = 8,
  localparam int BUS_W     = NUM_HALVES * HALF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BUS_W-1:0]      a_in,
  input  logic [BUS_W-1:0]      b_in,
  input  logic [NUM_HALVES-1:0] ce_ab_n,
  input  logic [NUM_HALVES-1:0] le_ab_n,
  input  logic [NUM_HALVES-1:0] oe_ab_n,
  input  logic [NUM_HALVES-1:0] ce_ba_n,
  input  logic [NUM_HALVES-1:0] le_ba_n,
  input  logic [NUM_HALVES-1:0] oe_ba_n,
  output logic [BUS_W-1:0]      a_out,
  output logic [BUS_W-1:0]      a_oe,
  output logic [BUS_W-1:0]      b_out,
  output logic [BUS_W-1:0]      b_oe,
  output logic [NUM_HALVES-1:0] contention
);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dir_ctl_t ab_ctl;
    dir_ctl_t ba_ctl;

    assign ab_ctl = '{ce_n: ce_ab_n[h], le_n: le_ab_n[h], oe_n: oe_ab_n[h]};
    assign ba_ctl = '{ce_n: ce_ba_n[h], le_n: le_ba_n[h], oe_n: oe_ba_n[h]};

    xcvr_half #(.W(HALF_W)) half_i (
      .clk   (clk),
      .rst   (rst),
      .ab_ctl(ab_ctl),
      .ba_ctl(ba_ctl),
      .a_in  (a_in[h*HALF_W +: HALF_W]),
      .b_in  (b_in[h*HALF_W +: HALF_W]),
      .a_out (a_out[h*HALF_W +: HALF_W]),
      .a_oe  (a_oe[h*HALF_W +: HALF_W]),
      .b_out (b_out[h*HALF_W +: HALF_W]),
      .b_oe  (b_oe[h*HALF_W +: HALF_W]),
      .clash (contention[h])
    );
  end

endmodule

// File: tb/bus_xcvr16_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr16_tb_top;

  localparam int NH = 2;
  localparam int W  = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   a_in = '0, b_in = '0;
  logic [NH-1:0] ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
  logic [NH-1:0] ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
  logic [15:0]   a_out, a_oe, b_out, b_oe;
  logic [NH-1:0] contention;

  int tests = 0;
  int fails = 0;

  bus_xcvr16 #(.NUM_HALVES(NH), .HALF_W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .contention(contention)
  );

  always #10 clk = ~clk;

  // Vector: tag[44:41] ctl{ce_ab,le_ab,oe_ab,ce_ba,le_ba,oe_ba}[40:35]
  // a[34:27] b[26:19] exp_b[18:11] exp_boe[10] exp_a[9:2] exp_aoe[1] exp_cont[0]
  localparam logic [44:0] VEC [NV] = '{
    {4'd3, 6'b111_111, 8'h11, 8'h22, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd7, 6'b010_111, 8'h33, 8'h22, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd2, 6'b000_111, 8'h5A, 8'h22, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd4, 6'b010_111, 8'hC3, 8'h22, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd3, 6'b100_111, 8'h77, 8'h22, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd3, 6'b010_111, 8'h77, 8'h22, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd5, 6'b001_111, 8'h96, 8'h22, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd5, 6'b010_111, 8'h00, 8'h22, 8'h96, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd6, 6'b111_000, 8'h00, 8'hE1, 8'h00, 1'b0, 8'hE1, 1'b1, 1'b0},
    {4'd6, 6'b111_010, 8'h00, 8'h3C, 8'h00, 1'b0, 8'hE1, 1'b1, 1'b0},
    {4'd9, 6'b010_010, 8'h00, 8'h3C, 8'h96, 1'b1, 8'hE1, 1'b1, 1'b1},
    {4'd9, 6'b010_011, 8'h00, 8'h3C, 8'h96, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_half(input int h, input logic [5:0] c,
                          input logic [7:0] a, input logic [7:0] b);
    {ce_ab_n[h], le_ab_n[h], oe_ab_n[h], ce_ba_n[h], le_ba_n[h], oe_ba_n[h]} = c;
    a_in[h*8 +: 8] = a;
    b_in[h*8 +: 8] = b;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    // R8: idle state after reset
    chk("R8", {a_out, b_out}, 32'h0);
    chk("R8", {a_oe, b_oe}, 32'h0);
    chk("R8", {30'h0, contention}, 32'h0);

    // Vector walk on half 0, half 1 idle with all enables high
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_half(0, VEC[i][40:35], VEC[i][34:27], VEC[i][26:19]);
      set_half(1, 6'b111_111, 8'hFF, 8'hFF);
      #2;
      chk(tag_of(VEC[i][44:41]), {24'h0, b_out[7:0]}, {24'h0, VEC[i][18:11]});
      chk(tag_of(VEC[i][44:41]), {16'h0, b_oe[7:0], a_oe[7:0]},
          {16'h0, {8{VEC[i][10]}}, {8{VEC[i][1]}}});
      chk(tag_of(VEC[i][44:41]), {24'h0, a_out[7:0]}, {24'h0, VEC[i][9:2]});
      chk(tag_of(VEC[i][44:41]), {31'h0, contention[0]}, {31'h0, VEC[i][0]});
      // R1: idle half untouched
      chk("R1", {a_out[15:8], a_oe[15:8], b_out[15:8], b_oe[15:8]}, 32'h0);
    end

    // R1: half 1 transparent while half 0 shows its own held byte
    @(negedge clk);
    set_half(0, 6'b010_111, 8'hFF, 8'hFF);
    set_half(1, 6'b000_111, 8'hAB, 8'h00);
    #2;
    chk("R1", {16'h0, b_out}, {16'h0, 8'hAB, 8'h96});
    chk("R1", {16'h0, b_oe}, 32'h0000FFFF);
    @(negedge clk);
    set_half(0, 6'b100_111, 8'hFF, 8'hFF);
    set_half(1, 6'b010_111, 8'h00, 8'h00);
    #2;
    chk("R1", {16'h0, b_out}, {16'h0, 8'hAB, 8'h00});
    chk("R1", {16'h0, b_oe}, 32'h0000FF00);

    // R7: reset clears every stage; R9 on both halves
    @(negedge clk);
    set_half(0, 6'b111_111, 8'h00, 8'h00);
    set_half(1, 6'b111_111, 8'h00, 8'h00);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    set_half(0, 6'b010_010, 8'h55, 8'h55);
    set_half(1, 6'b010_010, 8'h55, 8'h55);
    #2;
    chk("R7", {a_out, b_out}, 32'h0);
    chk("R7", {a_oe, b_oe}, 32'hFFFFFFFF);
    chk("R9", {30'h0, contention}, 32'h3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule